// File: doc/BRIEF.md
# Synthesizer Start-Up Calibration Sequencer

This block walks a fractional-N frequency synthesizer from standby to the start of loop acquisition. It runs on the phase-detector clock. A rising edge on `enable` starts a fixed series of stages: first a VCO warm-up wait, then a coarse-tune calibration window, then a VCO gain calibration window, and finally a PLL acquire state. The acquire state lasts until `enable` drops.

Each stage's length is the sum of a timer term and a power-of-two averaging term. The timer field is scaled by a fixed multiplier. The averaging term is 16 × 2^n. Each calibration has its own enable bit. A disabled calibration still uses its full window, so the only way to shorten a stage is to zero its fields. There is one exception: when the averaging-skip control is set, a disabled calibration drops its averaging term. A stage whose length comes out as zero is skipped entirely.

The block drives a one-hot set of stage-active strobes and a one-cycle pulse on entry to acquisition. It also drives the 7-bit coarse-tune capacitor code to apply. When coarse calibration is disabled, that code is the programmed default. When it is enabled, the code is the external search result, captured into a readback register at the end of the coarse stage.

Top module: `synth_start_seq`

## Requirements
- R1: A sequence starts only on a 0-to-1 transition of `enable`. Holding `enable` high out of reset starts nothing. Stages always occur in the order warm-up, coarse, gain, acquire.
- R2: The warm-up stage lasts `vcoWarmTime` × 32 clock cycles.
- R3: The coarse stage lasts `ctTime` × 32 + 16 × 2^`ctAvgSel` cycles.
- R4: The gain stage lasts (`kvTime1` + `kvTime2`) × 256 + 16 × 2^`kvAvgSel` cycles.
- R5: A disabled calibration still takes its full stage length as given in R3 and R4 when `skipAvg` is 0.
- R6: When `skipAvg` is 1, a stage whose calibration is disabled leaves out its averaging term. An enabled calibration always keeps its averaging term. A stage of zero length is skipped in zero cycles, so all-zero fields reach acquire in the cycle right after the enable edge.
- R7: While the captured coarse enable is 0, `ctCode` equals the `ctDefaultCode` captured at the enable edge, and `ctReadback` keeps its earlier value.
- R8: With coarse calibration enabled, `ctSearchCode` is captured into `ctReadback` on the last cycle of the coarse stage. From then on, `ctCode` equals that captured value. `ctReadback` is 0 after reset.
- R9: If `enable` is low at a clock edge, every stage strobe, `acquire` and `acqStart` are low in the following cycle. A later rising edge restarts the sequence from warm-up.
- R10: `acqStart` is high for exactly the first cycle of the acquire state. `acquire` then stays high for as long as `enable` stays high.
- R11: All stage fields, both calibration enables, `skipAvg` and `ctDefaultCode` are sampled at the enable edge. Changing them mid-sequence does not change the running sequence.
- R12: At most one of `warmActive`, `ctCalActive`, `kvCalActive`, `acquire` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Synthesizer enable; rising edge starts a sequence |
| vcoWarmTime | input | 5 | Warm-up timer, ×32 cycles |
| ctTime | input | 5 | Coarse-tune timer, ×32 cycles |
| ctAvgSel | input | 2 | Coarse averaging exponent |
| kvTime1 | input | 4 | First gain timer, ×256 cycles |
| kvTime2 | input | 4 | Second gain timer, ×256 cycles |
| kvAvgSel | input | 2 | Gain averaging exponent |
| ctCalEn | input | 1 | Coarse-tune calibration enable |
| kvCalEn | input | 1 | Gain calibration enable |
| skipAvg | input | 1 | Drop averaging of disabled calibrations |
| ctDefaultCode | input | 7 | Coarse code used when calibration is off |
| ctSearchCode | input | 7 | Result of the external coarse search |
| warmActive | output | 1 | Warm-up stage active |
| ctCalActive | output | 1 | Coarse-tune stage active |
| kvCalActive | output | 1 | Gain calibration stage active |
| acquire | output | 1 | PLL acquire state |
| acqStart | output | 1 | One-cycle pulse on entry to acquire |
| ctCode | output | 7 | Coarse capacitor code to apply |
| ctReadback | output | 7 | Last calibrated coarse code |

## Verification
The bench measures the length of every stage in cycles, for directed and random field sets, and compares each length with the formulas.

- A design that dropped the averaging term of a disabled calibration, or that ignored `skipAvg`, would show a stage that is too long or too short.
- A design that mishandled zero-length stages would show a stray one-cycle stage, or a late `acqStart` when all fields are zero.
- Mid-sequence field changes would catch a design that reads live fields instead of the values captured at the edge.
- Aborting `enable` partway through, and then restarting, would catch a counter or state that is not cleared.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WARM  = 3'd1,
    ST_CTCAL = 3'd2,
    ST_KVCAL = 3'd3,
    ST_ACQ   = 3'd4
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      useLive;   // fields track the inputs (idle)
    logic      cntClr;    // restart the stage counter
    seqState_e stage;     // stage whose length is compared
    logic      ctLatch;   // last cycle of the coarse stage
  } seqCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic stageDone;
    logic warmZero;
    logic ctZero;
    logic kvZero;
  } seqStat_t;

endpackage

// File: rtl/synth_seq_dp.sv
module synth_seq_dp
  import synth_seq_pkg::*;
#(
  parameter int TVCO_W   = 5,
  parameter int TCT_W    = 5,
  parameter int TKV_W    = 4,
  parameter int AVG_W    = 2,
  parameter int CODE_W   = 7,
  parameter int WARM_SH  = 5,
  parameter int CT_SH    = 5,
  parameter int KV_SH    = 8,
  parameter int AVG_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  output seqStat_t          stat,
  input  logic [TVCO_W-1:0] vcoWarmTime,
  input  logic [TCT_W-1:0]  ctTime,
  input  logic [AVG_W-1:0]  ctAvgSel,
  input  logic [TKV_W-1:0]  kvTime1,
  input  logic [TKV_W-1:0]  kvTime2,
  input  logic [AVG_W-1:0]  kvAvgSel,
  input  logic              ctCalEn,
  input  logic              kvCalEn,
  input  logic              skipAvg,
  input  logic [CODE_W-1:0] ctDefaultCode,
  input  logic [CODE_W-1:0] ctSearchCode,
  output logic [CODE_W-1:0] ctCode,
  output logic [CODE_W-1:0] ctReadback
);

  localparam int AVG_MAX_BITS = AVG_BASE + (1 << AVG_W);
  localparam int WARM_BITS    = TVCO_W + WARM_SH;
  localparam int CT_BITS      = TCT_W + CT_SH + 1;
  localparam int KV_BITS      = TKV_W + KV_SH + 2;
  localparam int M1           = (WARM_BITS > CT_BITS) ? WARM_BITS : CT_BITS;
  localparam int M2           = (M1 > KV_BITS) ? M1 : KV_BITS;
  localparam int CNT_W        = ((M2 > AVG_MAX_BITS) ? M2 : AVG_MAX_BITS) + 1;

  // fields captured at the enable edge
  logic [TVCO_W-1:0] tvcoQ;
  logic [TCT_W-1:0]  tctQ;
  logic [AVG_W-1:0]  ctAvgQ, kvAvgQ;
  logic [TKV_W-1:0]  tkv1Q, tkv2Q;
  logic              ctEnQ, kvEnQ, skipQ;
  logic [CODE_W-1:0] defCodeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tvcoQ    <= '0;
      tctQ     <= '0;
      ctAvgQ   <= '0;
      kvAvgQ   <= '0;
      tkv1Q    <= '0;
      tkv2Q    <= '0;
      ctEnQ    <= 1'b0;
      kvEnQ    <= 1'b0;
      skipQ    <= 1'b0;
      defCodeQ <= '0;
    end else if (ctrl.useLive) begin
      tvcoQ    <= vcoWarmTime;
      tctQ     <= ctTime;
      ctAvgQ   <= ctAvgSel;
      kvAvgQ   <= kvAvgSel;
      tkv1Q    <= kvTime1;
      tkv2Q    <= kvTime2;
      ctEnQ    <= ctCalEn;
      kvEnQ    <= kvCalEn;
      skipQ    <= skipAvg;
      defCodeQ <= ctDefaultCode;
    end
  end

  // effective fields: live while idle, frozen once running
  logic [TVCO_W-1:0] effTvco;
  logic [TCT_W-1:0]  effTct;
  logic [AVG_W-1:0]  effCtAvg, effKvAvg;
  logic [TKV_W-1:0]  effTkv1, effTkv2;
  logic              effCtEn, effKvEn, effSkip;
  logic [CODE_W-1:0] effDef;

  assign effTvco  = ctrl.useLive ? vcoWarmTime   : tvcoQ;
  assign effTct   = ctrl.useLive ? ctTime        : tctQ;
  assign effCtAvg = ctrl.useLive ? ctAvgSel      : ctAvgQ;
  assign effKvAvg = ctrl.useLive ? kvAvgSel      : kvAvgQ;
  assign effTkv1  = ctrl.useLive ? kvTime1       : tkv1Q;
  assign effTkv2  = ctrl.useLive ? kvTime2       : tkv2Q;
  assign effCtEn  = ctrl.useLive ? ctCalEn       : ctEnQ;
  assign effKvEn  = ctrl.useLive ? kvCalEn       : kvEnQ;
  assign effSkip  = ctrl.useLive ? skipAvg       : skipQ;
  assign effDef   = ctrl.useLive ? ctDefaultCode : defCodeQ;

  // stage lengths
  logic [CNT_W-1:0] warmLen, ctLen, kvLen, ctAvgLen, kvAvgLen, curLen;

  assign ctAvgLen = (effSkip && !effCtEn) ? '0 : (CNT_W'(1) << (AVG_BASE + int'(effCtAvg)));
  assign kvAvgLen = (effSkip && !effKvEn) ? '0 : (CNT_W'(1) << (AVG_BASE + int'(effKvAvg)));
  assign warmLen  = CNT_W'(effTvco) << WARM_SH;
  assign ctLen    = (CNT_W'(effTct) << CT_SH) + ctAvgLen;
  assign kvLen    = ((CNT_W'(effTkv1) + CNT_W'(effTkv2)) << KV_SH) + kvAvgLen;

  always_comb begin
    case (ctrl.stage)
      ST_WARM:  curLen = warmLen;
      ST_CTCAL: curLen = ctLen;
      ST_KVCAL: curLen = kvLen;
      default:  curLen = '0;
    endcase
  end

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (ctrl.cntClr) count <= '0;
    else                  count <= count + 1'b1;
  end

  assign stat.stageDone = (curLen != '0) && (count == curLen - 1'b1);
  assign stat.warmZero  = (warmLen == '0);
  assign stat.ctZero    = (ctLen == '0);
  assign stat.kvZero    = (kvLen == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         ctReadback <= '0;
    else if (ctrl.ctLatch && effCtEn)  ctReadback <= ctSearchCode;
  end

  assign ctCode = effCtEn ? ctReadback : effDef;

  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.ctLatch |=> $stable(ctReadback)); // R8

  AST_CNT_IN_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stage inside {ST_WARM, ST_CTCAL, ST_KVCAL}) |-> (count < curLen)); // R2

endmodule

// File: rtl/synth_seq_ctrl.sv
module synth_seq_ctrl
  import synth_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     warmActive,
  output logic     ctCalActive,
  output logic     kvCalActive,
  output logic     acquire,
  output logic     acqStart
);

  seqState_e state, nextState;
  logic      enPrev, enRise;

  assign enRise = enable && !enPrev;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:
        if (enRise)
          nextState = !stat.warmZero ? ST_WARM :
                      !stat.ctZero   ? ST_CTCAL :
                      !stat.kvZero   ? ST_KVCAL : ST_ACQ;
      ST_WARM:
        if (stat.stageDone)
          nextState = !stat.ctZero ? ST_CTCAL :
                      !stat.kvZero ? ST_KVCAL : ST_ACQ;
      ST_CTCAL:
        if (stat.stageDone)
          nextState = !stat.kvZero ? ST_KVCAL : ST_ACQ;
      ST_KVCAL:
        if (stat.stageDone) nextState = ST_ACQ;
      default: nextState = state;
    endcase
    if (!enable) nextState = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      enPrev   <= 1'b1;
      acqStart <= 1'b0;
    end else begin
      state    <= nextState;
      enPrev   <= enable;
      acqStart <= (nextState == ST_ACQ) && (state != ST_ACQ);
    end
  end

  assign ctrl.useLive = (state == ST_IDLE);
  assign ctrl.cntClr  = (nextState != state) || (state == ST_IDLE) || (state == ST_ACQ);
  assign ctrl.stage   = state;
  assign ctrl.ctLatch = (state == ST_CTCAL) && stat.stageDone && enable;

  assign warmActive  = (state == ST_WARM);
  assign ctCalActive = (state == ST_CTCAL);
  assign kvCalActive = (state == ST_KVCAL);
  assign acquire     = (state == ST_ACQ);

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({warmActive, ctCalActive, kvCalActive, acquire})); // R12

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |=> !acqStart); // R10

  AST_ACQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (acquire && enable) |=> acquire); // R10

  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !(warmActive || ctCalActive || kvCalActive || acquire || acqStart)); // R9

  AST_NO_BACKWARD: assert property (@(posedge clk) disable iff (!rstN)
    kvCalActive |=> !(warmActive || ctCalActive)); // R1

endmodule

// File: rtl/synth_start_seq.sv
module synth_start_seq
  import synth_seq_pkg::*;
#(
  parameter int TVCO_W   = 5,
  parameter int TCT_W    = 5,
  parameter int TKV_W    = 4,
  parameter int AVG_W    = 2,
  parameter int CODE_W   = 7,
  parameter int WARM_SH  = 5,
  parameter int CT_SH    = 5,
  parameter int KV_SH    = 8,
  parameter int AVG_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [TVCO_W-1:0] vcoWarmTime,
  input  logic [TCT_W-1:0]  ctTime,
  input  logic [AVG_W-1:0]  ctAvgSel,
  input  logic [TKV_W-1:0]  kvTime1,
  input  logic [TKV_W-1:0]  kvTime2,
  input  logic [AVG_W-1:0]  kvAvgSel,
  input  logic              ctCalEn,
  input  logic              kvCalEn,
  input  logic              skipAvg,
  input  logic [CODE_W-1:0] ctDefaultCode,
  input  logic [CODE_W-1:0] ctSearchCode,
  output logic              warmActive,
  output logic              ctCalActive,
  output logic              kvCalActive,
  output logic              acquire,
  output logic              acqStart,
  output logic [CODE_W-1:0] ctCode,
  output logic [CODE_W-1:0] ctReadback
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  synth_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .stat(stat), .ctrl(ctrl),
    .warmActive(warmActive), .ctCalActive(ctCalActive), .kvCalActive(kvCalActive),
    .acquire(acquire), .acqStart(acqStart)
  );

  synth_seq_dp #(
    .TVCO_W(TVCO_W), .TCT_W(TCT_W), .TKV_W(TKV_W), .AVG_W(AVG_W), .CODE_W(CODE_W),
    .WARM_SH(WARM_SH), .CT_SH(CT_SH), .KV_SH(KV_SH), .AVG_BASE(AVG_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stat(stat),
    .vcoWarmTime(vcoWarmTime), .ctTime(ctTime), .ctAvgSel(ctAvgSel),
    .kvTime1(kvTime1), .kvTime2(kvTime2), .kvAvgSel(kvAvgSel),
    .ctCalEn(ctCalEn), .kvCalEn(kvCalEn), .skipAvg(skipAvg),
    .ctDefaultCode(ctDefaultCode), .ctSearchCode(ctSearchCode),
    .ctCode(ctCode), .ctReadback(ctReadback)
  );

endmodule

// File: tb/tb_synth_start_seq.sv
module tb_synth_start_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic [4:0] vcoWarmTime = '0, ctTime = '0;
  logic [1:0] ctAvgSel = '0, kvAvgSel = '0;
  logic [3:0] kvTime1 = '0, kvTime2 = '0;
  logic       ctCalEn = 1'b0, kvCalEn = 1'b0, skipAvg = 1'b0;
  logic [6:0] ctDefaultCode = '0, ctSearchCode = '0;
  logic       warmActive, ctCalActive, kvCalActive, acquire, acqStart;
  logic [6:0] ctCode, ctReadback;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  synth_start_seq dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .vcoWarmTime(vcoWarmTime), .ctTime(ctTime), .ctAvgSel(ctAvgSel),
    .kvTime1(kvTime1), .kvTime2(kvTime2), .kvAvgSel(kvAvgSel),
    .ctCalEn(ctCalEn), .kvCalEn(kvCalEn), .skipAvg(skipAvg),
    .ctDefaultCode(ctDefaultCode), .ctSearchCode(ctSearchCode),
    .warmActive(warmActive), .ctCalActive(ctCalActive), .kvCalActive(kvCalActive),
    .acquire(acquire), .acqStart(acqStart), .ctCode(ctCode), .ctReadback(ctReadback)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expWarm(input int tv);
    return tv * 32;
  endfunction

  function automatic int expCt(input int tct, input int n1, input bit en, input bit skip);
    return tct * 32 + ((skip && !en) ? 0 : (16 << n1));
  endfunction

  function automatic int expKv(input int t1, input int t2, input int n2, input bit en, input bit skip);
    return (t1 + t2) * 256 + ((skip && !en) ? 0 : (16 << n2));
  endfunction

  task automatic setFields(input int tv, input int tct, input int n1, input int t1, input int t2,
                           input int n2, input bit cen, input bit ken, input bit sk, input int def);
    vcoWarmTime = 5'(tv); ctTime = 5'(tct); ctAvgSel = 2'(n1);
    kvTime1 = 4'(t1); kvTime2 = 4'(t2); kvAvgSel = 2'(n2);
    ctCalEn = cen; kvCalEn = ken; skipAvg = sk; ctDefaultCode = 7'(def);
  endtask

  // one full sequence with checks; fields must already be set
  task automatic runSeq(input bit midChange);
    int eW, eC, eK, nW, nC, nK, lastIdx, idx, waitN;
    bit orderOk, oneHotOk, cen, acqOk;
    int def, prevRb, search;
    eW = expWarm(vcoWarmTime);
    eC = expCt(ctTime, ctAvgSel, ctCalEn, skipAvg);
    eK = expKv(kvTime1, kvTime2, kvAvgSel, kvCalEn, skipAvg);
    cen = ctCalEn; def = ctDefaultCode; search = ctSearchCode;
    @(negedge clk); enable = 1'b0;
    @(negedge clk); @(negedge clk);
    prevRb = ctReadback;
    enable = 1'b1;
    nW = 0; nC = 0; nK = 0; lastIdx = 0; orderOk = 1; oneHotOk = 1; acqOk = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (midChange && i == 0)
        setFields(31 - vcoWarmTime, 0, 3, 2, 2, 3, !cen, !kvCalEn, !skipAvg, def ^ 7'h55);
      if ($countones({warmActive, ctCalActive, kvCalActive, acquire}) > 1) oneHotOk = 0;
      idx = warmActive ? 1 : ctCalActive ? 2 : kvCalActive ? 3 : acquire ? 4 : 0;
      if (idx < lastIdx || idx == 0) orderOk = 0;
      lastIdx = idx;
      if (warmActive) nW++;
      if (ctCalActive) nC++;
      if (kvCalActive) nK++;
      if (acquire) begin acqOk = 1; break; end
    end
    chk(acqOk, "R1", "reached acquire", acqOk, 1);
    chk(orderOk, "R1", "stage order", orderOk, 1);
    chk(oneHotOk, "R12", "strobes one-hot", oneHotOk, 1);
    chk(nW == eW, "R2", "warm length", nW, eW);
    chk(nC == eC, "R3", "coarse length", nC, eC);
    chk(nK == eK, "R4", "gain length", nK, eK);
    chk(acqStart == 1'b1, "R10", "acqStart on entry", acqStart, 1);
    waitN = 0;
    repeat (3) begin
      @(negedge clk);
      if (acqStart) waitN++;
      chk(acquire == 1'b1, "R10", "acquire held", acquire, 1);
    end
    chk(waitN == 0, "R10", "acqStart single cycle", waitN, 0);
    if (cen) begin
      chk(ctReadback == 7'(search), "R8", "readback", ctReadback, search);
      chk(ctCode == 7'(search), "R8", "code from search", ctCode, search);
    end else begin
      chk(ctReadback == 7'(prevRb), "R7", "readback unchanged", ctReadback, prevRb);
      chk(ctCode == 7'(def), "R7", "default code", ctCode, def);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    setFields(8, 15, 2, 0, 4, 0, 1, 0, 0, 7'h21);
    ctSearchCode = 7'h4D;
    repeat (3) @(negedge clk);
    chk(!warmActive && !acquire && !acqStart, "R9", "reset outputs idle", acquire, 0);
    chk(ctReadback == 7'd0, "R8", "readback reset", ctReadback, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(!warmActive && !ctCalActive && !acquire, "R1", "no start without edge", warmActive, 0);

    // default-like settings, gain calibration disabled but timed (R5)
    runSeq(0);
    // coarse disabled, skip off: full coarse window still elapses (R5)
    ctSearchCode = 7'h12;
    setFields(3, 2, 1, 1, 0, 2, 0, 0, 0, 7'h0A);
    runSeq(0);
    // fast settings: skip with disabled calibrations, zero timers (R6)
    setFields(8, 0, 3, 0, 0, 3, 0, 0, 1, 7'h4E);
    runSeq(0);
    // everything zero: acquire immediately (R6)
    setFields(0, 0, 0, 0, 0, 0, 0, 0, 1, 7'h33);
    runSeq(0);
    // skip set but coarse enabled keeps averaging (R6)
    ctSearchCode = 7'h66;
    setFields(0, 0, 1, 0, 0, 0, 1, 0, 1, 7'h01);
    runSeq(0);
    // mid-sequence field changes ignored (R11)
    ctSearchCode = 7'h2B;
    setFields(4, 3, 0, 1, 1, 1, 1, 1, 0, 7'h11);
    runSeq(1);

    // abort partway, then restart (R9)
    setFields(6, 1, 0, 0, 1, 0, 1, 0, 0, 7'h05);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); @(negedge clk); enable = 1'b1;
    repeat (20) @(negedge clk);
    chk(warmActive == 1'b1, "R9", "in warm before abort", warmActive, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!warmActive && !ctCalActive && !kvCalActive && !acquire && !acqStart,
        "R9", "idle after enable low", {warmActive, acquire}, 0);
    runSeq(0);

    // random field sets
    for (int k = 0; k < 15; k++) begin
      ctSearchCode = 7'($urandom);
      setFields($urandom % 32, $urandom % 32, $urandom % 4, $urandom % 3, $urandom % 3,
                $urandom % 4, 1'($urandom), 1'($urandom), 1'($urandom), $urandom % 128);
      runSeq(k % 4 == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule